// File: doc/BRIEF.md
# Decode Stage Stall and Skid Controller

This block sits at the decode position of a single-thread instruction pipeline. Each cycle it takes a group of up to W instructions from the fetch side and hands up to D of them to the rename side. Instructions are opaque to it. Each one carries a tag, a squashed marker and a source-operand count. Three downstream stages can ask it to hold with separate set and release pulses. The commit stage can flush it, or keep it frozen while its own recovery is still running. The block answers the fetch side with single-cycle hold and resume pulses.

Whatever cannot be forwarded is parked in a skid buffer. The buffer holds LAT·W + D entries, where LAT is the fetch-to-decode latency in cycles. After a hold ends, the stage first empties the buffer in an explicit draining state, Unblocking. It tells fetch to resume only once the buffer is empty.

The five states are IDLE, RUN, BLOCKED, UNBLOCKING and SQUASHING. The transitions are:
- IDLE/RUN to BLOCKED: on a hold, or when input is left over.
- BLOCKED to UNBLOCKING: when the holds clear.
- UNBLOCKING to RUN: when the buffer is drained.
- UNBLOCKING to BLOCKED: on a new hold.
- Any state to SQUASHING: on a flush or a freeze.
- SQUASHING to RUN: on the first cycle with no flush, freeze or hold.

All outputs are registered, so a decision made from the inputs of one cycle appears at the ports after the next rising edge.

Top module: `decode_skid_ctrl`

## Requirements
- R1: After reset, `stage_state` is IDLE (encoding 0), all hold flags are clear, and `out_valid`, `up_block`, `up_unblock` and `err` are low. The other state encodings are RUN=1, BLOCKED=2, UNBLOCKING=3 and SQUASHING=4.
- R2: There is one hold flag per downstream source, bit i of `stall_set`/`stall_clr`. A set pulse raises the flag and a clear pulse lowers it, and both act in the cycle they arrive. The stage is held whenever any flag is up.
- R3: Each cycle is decided in this priority order: flush (`squash_req`), then freeze (`squash_hold`), then hold, then leaving BLOCKED, then leaving SQUASHING. A freeze moves the state to SQUASHING and discards that cycle's input.
- R4: While held, all incoming instructions go into the skid buffer, nothing is forwarded, and the state becomes BLOCKED. `up_block` pulses only if the state was not already BLOCKED.
- R5: When the holds clear in BLOCKED, the state becomes UNBLOCKING. In BLOCKED or UNBLOCKING, output comes from the skid buffer, oldest first, and new arrivals are appended behind the buffered entries.
- R6: `up_unblock` pulses, and the state becomes RUN, only in a draining cycle that leaves the skid buffer empty.
- R7: A flush empties the skid buffer, discards that cycle's input and sets SQUASHING. It pulses `up_unblock` if the state was BLOCKED or UNBLOCKING. The next cycle with no flush, freeze or hold returns to RUN and forwards the live input.
- R8: At most D instructions are forwarded per cycle. They are packed into the low output lanes in arrival order. A squashed-marked instruction is dropped without taking a lane. If input remains after D lanes are filled, the rest is buffered, `up_block` pulses and the state becomes BLOCKED.
- R9: The skid buffer holds exactly LAT·W + D entries (6 with defaults). Filling it to capacity raises no error.
- R10: A forwarded instruction whose source-operand count is zero has its `out_rdy` bit set; otherwise that bit is clear.
- R11: `err` goes high and stays high until reset if the skid buffer would exceed its capacity, or if a clear pulse arrives for a source whose flag is down and is not being set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_cnt | input | $clog2(W+1) | Number of valid instructions in lanes 0..in_cnt-1 |
| in_tag | input | W*TW | Instruction tags, lane i at bits [i*TW +: TW] |
| in_squashed | input | W | Per-lane squashed marker |
| in_nsrc | input | W*SW | Per-lane source-operand count |
| stall_set | input | NSRC | Per-source hold set pulse |
| stall_clr | input | NSRC | Per-source hold clear pulse |
| squash_req | input | 1 | Flush request from commit |
| squash_hold | input | 1 | Commit is still recovering; stay frozen |
| out_valid | output | D | Per-lane forwarded-instruction valid |
| out_tag | output | D*TW | Forwarded tags, lane k at bits [k*TW +: TW] |
| out_rdy | output | D | Lane carries an instruction with no source operands |
| up_block | output | 1 | Hold pulse to fetch |
| up_unblock | output | 1 | Resume pulse to fetch |
| stage_state | output | 3 | Current state encoding |
| err | output | 1 | Sticky protocol or capacity error |

## Verification
The hardest situation to reach is the skid buffer filled exactly to its limit and then drained over several UNBLOCKING cycles, so that the resume pulse lines up with the cycle that takes the last entry. The stimulus raises a hold while feeding a full group and then a partial group, which reaches capacity with no error. It then releases the hold with no further input and checks three draining cycles in order. A second case pushes one group too many to show the overflow flag. Priority between a flush and a simultaneous hold is reached by firing both pulses in one cycle and watching the hold take effect on the following cycle.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RUN  = 3'd1,
        ST_BLK  = 3'd2,
        ST_UNB  = 3'd3,
        ST_SQ   = 3'd4
    } dsk_state_e;
endpackage

// File: rtl/dsk_stall_track.sv
module dsk_stall_track #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] flags_q,
    output logic            held_o,
    output logic            stray_o
);
    logic [NSRC-1:0] flags_d;

    always_comb begin
        flags_d = (flags_q | set_i) & ~clr_i;
        held_o  = |flags_d;
        stray_o = |(clr_i & ~(flags_q | set_i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        // R2
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_i[i] && !clr_i[i]) |=> flags_q[i]);
    end
endmodule

// File: rtl/dsk_lane_pick.sv
module dsk_lane_pick #(
    parameter int N     = 4,
    parameter int D     = 2,
    parameter int TW    = 8,
    parameter int SW    = 2,
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0] avail_i,
    input  logic [TW-1:0]    tag_i  [N],
    input  logic             sq_i   [N],
    input  logic [SW-1:0]    nsrc_i [N],
    output logic [D-1:0]     fv_o,
    output logic [TW-1:0]    ft_o   [D],
    output logic [D-1:0]     fr_o,
    output logic [CNT_W-1:0] used_o
);
    always_comb begin
        int slot;
        slot   = 0;
        used_o = '0;
        fv_o   = '0;
        fr_o   = '0;
        for (int k = 0; k < D; k++) ft_o[k] = '0;
        for (int i = 0; i < N; i++) begin
            if (i < int'(avail_i) && slot < D) begin
                used_o = CNT_W'(i + 1);
                if (!sq_i[i]) begin
                    fv_o[slot] = 1'b1;
                    ft_o[slot] = tag_i[i];
                    fr_o[slot] = (nsrc_i[i] == '0);
                    slot       = slot + 1;
                end
            end
        end
    end
endmodule

// File: rtl/dsk_skid_queue.sv
module dsk_skid_queue #(
    parameter int DEPTH = 6,
    parameter int W     = 4,
    parameter int TW    = 8,
    parameter int SW    = 2,
    parameter int QW    = 3,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic [QW-1:0] pop_n_i,
    input  logic [CW-1:0] push_n_i,
    input  logic [TW-1:0] push_tag_i  [W],
    input  logic          push_sq_i   [W],
    input  logic [SW-1:0] push_nsrc_i [W],
    output logic [TW-1:0] q_tag_o     [DEPTH],
    output logic          q_sq_o      [DEPTH],
    output logic [SW-1:0] q_nsrc_o    [DEPTH],
    output logic [QW-1:0] cnt_o,
    output logic          ovf_o
);
    logic [TW-1:0] n_tag  [DEPTH];
    logic          n_sq   [DEPTH];
    logic [SW-1:0] n_nsrc [DEPTH];
    int            rem;
    int            total;

    always_comb begin
        rem   = int'(cnt_o) - int'(pop_n_i);
        total = rem + int'(push_n_i);
        ovf_o = !flush_i && (total > DEPTH);
        for (int j = 0; j < DEPTH; j++) begin
            n_tag[j]  = '0;
            n_sq[j]   = 1'b0;
            n_nsrc[j] = '0;
            if (j < rem) begin
                n_tag[j]  = q_tag_o[j + int'(pop_n_i)];
                n_sq[j]   = q_sq_o[j + int'(pop_n_i)];
                n_nsrc[j] = q_nsrc_o[j + int'(pop_n_i)];
            end else if ((j - rem) < int'(push_n_i) && (j - rem) < W) begin
                n_tag[j]  = push_tag_i[j - rem];
                n_sq[j]   = push_sq_i[j - rem];
                n_nsrc[j] = push_nsrc_i[j - rem];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            cnt_o <= '0;
        end else if (total > DEPTH) begin
            cnt_o <= QW'(DEPTH);
        end else begin
            cnt_o <= QW'(total);
        end
        for (int j = 0; j < DEPTH; j++) begin
            q_tag_o[j]  <= n_tag[j];
            q_sq_o[j]   <= n_sq[j];
            q_nsrc_o[j] <= n_nsrc[j];
        end
    end
endmodule

// File: rtl/decode_skid_ctrl.sv
module decode_skid_ctrl
    import dsk_pkg::*;
#(
    parameter int W    = 4,
    parameter int D    = 2,
    parameter int LAT  = 1,
    parameter int TW   = 8,
    parameter int SW   = 2,
    parameter int NSRC = 3,
    localparam int DEPTH = LAT * W + D,
    localparam int CW    = $clog2(W + 1),
    localparam int QW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   in_cnt,
    input  logic [W*TW-1:0] in_tag,
    input  logic [W-1:0]    in_squashed,
    input  logic [W*SW-1:0] in_nsrc,
    input  logic [NSRC-1:0] stall_set,
    input  logic [NSRC-1:0] stall_clr,
    input  logic            squash_req,
    input  logic            squash_hold,
    output logic [D-1:0]    out_valid,
    output logic [D*TW-1:0] out_tag,
    output logic [D-1:0]    out_rdy,
    output logic            up_block,
    output logic            up_unblock,
    output logic [2:0]      stage_state,
    output logic            err
);
    dsk_state_e st, nxt;

    logic [TW-1:0] in_tag_a  [W];
    logic          in_sq_a   [W];
    logic [SW-1:0] in_nsrc_a [W];

    for (genvar i = 0; i < W; i++) begin : g_unpack
        assign in_tag_a[i]  = in_tag[i*TW +: TW];
        assign in_sq_a[i]   = in_squashed[i];
        assign in_nsrc_a[i] = in_nsrc[i*SW +: SW];
    end

    logic [NSRC-1:0] flags_q;
    logic            held, stray;

    dsk_stall_track #(.NSRC(NSRC)) u_track (
        .clk(clk), .rst_n(rst_n), .set_i(stall_set), .clr_i(stall_clr),
        .flags_q(flags_q), .held_o(held), .stray_o(stray)
    );

    logic [TW-1:0] q_tag  [DEPTH];
    logic          q_sq   [DEPTH];
    logic [SW-1:0] q_nsrc [DEPTH];
    logic [QW-1:0] sk_cnt;
    logic          ovf;

    logic [D-1:0]  lv_v, sk_v;
    logic [TW-1:0] lv_t [D];
    logic [TW-1:0] sk_t [D];
    logic [D-1:0]  lv_r, sk_r;
    logic [CW-1:0] lv_used;
    logic [QW-1:0] sk_used;

    dsk_lane_pick #(.N(W), .D(D), .TW(TW), .SW(SW), .CNT_W(CW)) u_pick_live (
        .avail_i(in_cnt), .tag_i(in_tag_a), .sq_i(in_sq_a), .nsrc_i(in_nsrc_a),
        .fv_o(lv_v), .ft_o(lv_t), .fr_o(lv_r), .used_o(lv_used)
    );

    dsk_lane_pick #(.N(DEPTH), .D(D), .TW(TW), .SW(SW), .CNT_W(QW)) u_pick_skid (
        .avail_i(sk_cnt), .tag_i(q_tag), .sq_i(q_sq), .nsrc_i(q_nsrc),
        .fv_o(sk_v), .ft_o(sk_t), .fr_o(sk_r), .used_o(sk_used)
    );

    logic          flush, use_live, use_skid, blk, ubl;
    logic [QW-1:0] pop_n;
    logic [CW-1:0] push_n;
    int            push_off;
    logic [TW-1:0] p_tag  [W];
    logic          p_sq   [W];
    logic [SW-1:0] p_nsrc [W];

    // Cycle decision: priority flush > freeze > hold > draining > live.
    always_comb begin
        int left;
        nxt      = st;
        flush    = 1'b0;
        use_live = 1'b0;
        use_skid = 1'b0;
        blk      = 1'b0;
        ubl      = 1'b0;
        pop_n    = '0;
        push_n   = '0;
        push_off = 0;
        left     = 0;
        if (squash_req) begin
            flush = 1'b1;
            nxt   = ST_SQ;
            ubl   = (st == ST_BLK) || (st == ST_UNB);
        end else if (squash_hold) begin
            nxt = ST_SQ;
        end else if (held) begin
            push_n = in_cnt;
            nxt    = ST_BLK;
            blk    = (st != ST_BLK);
        end else begin
            unique case (st)
                ST_BLK, ST_UNB: begin
                    use_skid = 1'b1;
                    pop_n    = sk_used;
                    push_n   = in_cnt;
                    left     = int'(sk_cnt) - int'(sk_used) + int'(in_cnt);
                    if (left == 0) begin
                        nxt = ST_RUN;
                        ubl = 1'b1;
                    end else begin
                        nxt = ST_UNB;
                    end
                end
                default: begin
                    use_live = 1'b1;
                    if (st == ST_SQ) nxt = ST_RUN;
                    left = int'(in_cnt) - int'(lv_used);
                    if (left > 0) begin
                        push_n   = CW'(left);
                        push_off = int'(lv_used);
                        nxt      = ST_BLK;
                        blk      = 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        for (int j = 0; j < W; j++) begin
            p_tag[j]  = '0;
            p_sq[j]   = 1'b0;
            p_nsrc[j] = '0;
            if (j + push_off < W) begin
                p_tag[j]  = in_tag_a[j + push_off];
                p_sq[j]   = in_sq_a[j + push_off];
                p_nsrc[j] = in_nsrc_a[j + push_off];
            end
        end
    end

    dsk_skid_queue #(.DEPTH(DEPTH), .W(W), .TW(TW), .SW(SW), .QW(QW), .CW(CW)) u_skid (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .pop_n_i(pop_n), .push_n_i(push_n),
        .push_tag_i(p_tag), .push_sq_i(p_sq), .push_nsrc_i(p_nsrc),
        .q_tag_o(q_tag), .q_sq_o(q_sq), .q_nsrc_o(q_nsrc), .cnt_o(sk_cnt), .ovf_o(ovf)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    assign stage_state = st;

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= '0;
            out_tag    <= '0;
            out_rdy    <= '0;
            up_block   <= 1'b0;
            up_unblock <= 1'b0;
            err        <= 1'b0;
        end else begin
            up_block   <= blk;
            up_unblock <= ubl;
            err        <= err | ovf | stray;
            for (int k = 0; k < D; k++) begin
                out_valid[k]         <= use_skid ? sk_v[k] : (use_live & lv_v[k]);
                out_tag[k*TW +: TW]  <= use_skid ? sk_t[k] : (use_live ? lv_t[k] : '0);
                out_rdy[k]           <= use_skid ? sk_r[k] : (use_live & lv_r[k]);
            end
        end
    end

    // R4
    no_dual_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_block && up_unblock));

    // R3
    flush_to_sq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash_req |=> (stage_state == 3'd4));

    // R4
    hold_to_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !squash_req && !squash_hold) |=> (stage_state == 3'd2));

    // R6
    resume_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_unblock |-> (sk_cnt == '0));
endmodule

// File: tb/decode_skid_ctrl_bench.sv
module decode_skid_ctrl_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  in_cnt = '0;
    logic [31:0] in_tag = '0;
    logic [3:0]  in_squashed = '0;
    logic [7:0]  in_nsrc = '0;
    logic [2:0]  stall_set = '0;
    logic [2:0]  stall_clr = '0;
    logic        squash_req = 1'b0;
    logic        squash_hold = 1'b0;
    logic [1:0]  out_valid;
    logic [15:0] out_tag;
    logic [1:0]  out_rdy;
    logic        up_block, up_unblock, err;
    logic [2:0]  stage_state;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    decode_skid_ctrl u_decode_skid_ctrl (
        .clk(clk), .rst_n(rst_n), .in_cnt(in_cnt), .in_tag(in_tag),
        .in_squashed(in_squashed), .in_nsrc(in_nsrc), .stall_set(stall_set),
        .stall_clr(stall_clr), .squash_req(squash_req), .squash_hold(squash_hold),
        .out_valid(out_valid), .out_tag(out_tag), .out_rdy(out_rdy),
        .up_block(up_block), .up_unblock(up_unblock), .stage_state(stage_state), .err(err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic quiet();
        in_cnt = '0; in_tag = '0; in_squashed = '0; in_nsrc = '0;
        stall_set = '0; stall_clr = '0; squash_req = 1'b0; squash_hold = 1'b0;
    endtask

    // lane i: tag base+i, squashed per sqm, zero operands where zm bit set
    task automatic feed(input int n, input logic [7:0] base, input logic [3:0] sqm, input logic [3:0] zm);
        in_cnt = 3'(n);
        in_squashed = sqm;
        for (int i = 0; i < 4; i++) begin
            in_tag[i*8 +: 8]  = base + 8'(i);
            in_nsrc[i*2 +: 2] = zm[i] ? 2'd0 : 2'd1;
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        quiet();
    endtask

    task automatic expect_out(input string req, input logic [1:0] v, input logic [7:0] t0, input logic [7:0] t1);
        chk(req, "out_valid", int'(out_valid), int'(v));
        if (v[0]) chk(req, "tag0", int'(out_tag[7:0]), int'(t0));
        if (v[1]) chk(req, "tag1", int'(out_tag[15:8]), int'(t1));
    endtask

    task automatic do_reset();
        quiet();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1", "state", int'(stage_state), 0);
        chk("R1", "out_valid", int'(out_valid), 0);
        chk("R1", "up_block", int'(up_block), 0);
        chk("R1", "up_unblock", int'(up_unblock), 0);
        chk("R1", "err", int'(err), 0);
    endtask

    task automatic t_pass();
        feed(2, 8'h10, 4'b0000, 4'b0010);
        step();
        expect_out("R8", 2'b11, 8'h10, 8'h11);
        chk("R10", "out_rdy", int'(out_rdy), 2);
        chk("R1", "idle kept", int'(stage_state), 0);
        feed(3, 8'h20, 4'b0010, 4'b0000);
        step();
        expect_out("R8", 2'b11, 8'h20, 8'h22);
        chk("R8", "no block on skip", int'(up_block), 0);
        chk("R10", "out_rdy none", int'(out_rdy), 0);
    endtask

    task automatic t_over();
        feed(4, 8'h30, 4'b0000, 4'b0100);
        step();
        expect_out("R8", 2'b11, 8'h30, 8'h31);
        chk("R8", "up_block", int'(up_block), 1);
        chk("R8", "state blk", int'(stage_state), 2);
        step();
        expect_out("R5", 2'b11, 8'h32, 8'h33);
        chk("R10", "rdy from skid", int'(out_rdy), 1);
        chk("R6", "up_unblock", int'(up_unblock), 1);
        chk("R6", "state run", int'(stage_state), 1);
        chk("R4", "block dropped", int'(up_block), 0);
    endtask

    task automatic t_stall();
        feed(2, 8'h40, 4'b0000, 4'b0000);
        stall_set = 3'b010;
        step();
        chk("R2", "held no out", int'(out_valid), 0);
        chk("R4", "up_block", int'(up_block), 1);
        chk("R4", "state blk", int'(stage_state), 2);
        feed(2, 8'h42, 4'b0000, 4'b0000);
        step();
        chk("R4", "no repeat block", int'(up_block), 0);
        chk("R2", "still held", int'(out_valid), 0);
        feed(1, 8'h44, 4'b0000, 4'b0000);
        stall_clr = 3'b010;
        step();
        expect_out("R5", 2'b11, 8'h40, 8'h41);
        chk("R5", "state unb", int'(stage_state), 3);
        chk("R6", "no early resume", int'(up_unblock), 0);
        step();
        expect_out("R5", 2'b11, 8'h42, 8'h43);
        chk("R6", "no early resume 2", int'(up_unblock), 0);
        step();
        expect_out("R5", 2'b01, 8'h44, 8'h00);
        chk("R6", "resume", int'(up_unblock), 1);
        chk("R6", "state run", int'(stage_state), 1);
        chk("R11", "no err on matched clear", int'(err), 0);
    endtask

    task automatic t_flush_blocked();
        feed(2, 8'h50, 4'b0000, 4'b0000);
        stall_set = 3'b001;
        step();
        chk("R4", "state blk", int'(stage_state), 2);
        feed(2, 8'h60, 4'b0000, 4'b0000);
        squash_req = 1'b1;
        stall_clr = 3'b001;
        step();
        chk("R7", "state sq", int'(stage_state), 4);
        chk("R7", "unblock on flush", int'(up_unblock), 1);
        chk("R7", "no out", int'(out_valid), 0);
        feed(2, 8'h70, 4'b0000, 4'b0000);
        step();
        chk("R7", "back to run", int'(stage_state), 1);
        expect_out("R7", 2'b11, 8'h70, 8'h71);
        step();
        chk("R7", "skid flushed", int'(out_valid), 0);
    endtask

    task automatic t_freeze();
        feed(2, 8'h80, 4'b0000, 4'b0000);
        squash_hold = 1'b1;
        step();
        chk("R3", "freeze state", int'(stage_state), 4);
        chk("R3", "freeze no out", int'(out_valid), 0);
        feed(1, 8'h90, 4'b0000, 4'b0000);
        step();
        chk("R3", "thaw run", int'(stage_state), 1);
        expect_out("R3", 2'b01, 8'h90, 8'h00);
        step();
        chk("R3", "frozen input gone", int'(out_valid), 0);
    endtask

    task automatic t_prio();
        squash_req = 1'b1;
        stall_set = 3'b100;
        step();
        chk("R3", "flush wins", int'(stage_state), 4);
        chk("R3", "no block on flush", int'(up_block), 0);
        step();
        chk("R3", "hold next", int'(stage_state), 2);
        chk("R4", "block from sq", int'(up_block), 1);
        stall_clr = 3'b100;
        step();
        chk("R6", "empty resume", int'(up_unblock), 1);
        chk("R6", "state run", int'(stage_state), 1);
    endtask

    task automatic t_depth();
        do_reset();
        feed(4, 8'hA0, 4'b0000, 4'b0000);
        stall_set = 3'b001;
        step();
        feed(2, 8'hB0, 4'b0000, 4'b0000);
        step();
        chk("R9", "full no err", int'(err), 0);
        stall_clr = 3'b001;
        step();
        expect_out("R9", 2'b11, 8'hA0, 8'hA1);
        step();
        expect_out("R9", 2'b11, 8'hA2, 8'hA3);
        chk("R9", "no resume yet", int'(up_unblock), 0);
        step();
        expect_out("R9", 2'b11, 8'hB0, 8'hB1);
        chk("R9", "resume at drain", int'(up_unblock), 1);
        chk("R9", "still no err", int'(err), 0);
    endtask

    task automatic t_errors();
        do_reset();
        feed(4, 8'hC0, 4'b0000, 4'b0000);
        stall_set = 3'b001;
        step();
        feed(3, 8'hC4, 4'b0000, 4'b0000);
        step();
        chk("R11", "overflow err", int'(err), 1);
        step();
        chk("R11", "err sticky", int'(err), 1);
        do_reset();
        chk("R1", "err reset", int'(err), 0);
        stall_clr = 3'b100;
        step();
        chk("R11", "stray clear err", int'(err), 1);
    endtask

    initial begin
        #(PERIOD * 5000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset();
        t_pass();
        t_over();
        t_stall();
        t_flush_blocked();
        t_freeze();
        t_prio();
        t_depth();
        t_errors();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule